// File: doc/BRIEF.md
# Dual-Mode Attenuation Control Register

This block is the digital front end of a step attenuator. It holds a 7-bit attenuation code at 0.25 dB per step, so code 127 is 31.75 dB. The code can be written from seven parallel data pins or from a serial data/clock pair. A path select pin picks between them.

All pins are sampled on the system clock. The parallel path is a transparent latch gated by the latch enable: with the enable held high the code follows the pins (direct operation), and a high-then-low pulse captures a value (latched operation). The serial path is an 8-bit shift register that is filled least significant bit first. It feeds the same enable-gated latch. The eighth bit is a validity marker: a latched serial word with that bit set raises an invalid flag, and parallel writes are locked out until a clean serial word clears it.

After reset the code starts at maximum attenuation. A preset window of a fixed number of microseconds, counted in system clocks, then elapses before any write takes effect. As a result, direct operation comes up at maximum attenuation and moves to the pin value only when the window has closed.

Top module: `att_ctrl`

## Requirements
- R1: While reset is asserted and on release, `att_code` is 127 (all ones) and `bad_word` is 0.
- R2: For PRESET_US microseconds of system clock after reset release (20000 cycles at the defaults), no write takes effect and `att_code` stays 127.
- R3: With `ser_sel`=0 and `lat_en`=1, `att_code` takes the value on `par_data` one clock after it is sampled. A pin value held through the preset window appears right after it.
- R4: With `ser_sel`=0 and `lat_en`=0, changes on `par_data` have no effect. After a `lat_en` high-then-low pulse, `att_code` holds the pin value sampled in the last clock with `lat_en` high.
- R5: With `ser_sel`=1, each sampled rising edge of `ser_clk` shifts `ser_din` into an 8-bit register, least significant bit first. After eight edges, word bit 0 is the first bit sent and bit 7 is the last.
- R6: With `ser_sel`=1 and `lat_en`=0, shifting does not change `att_code` or `bad_word`.
- R7: With `ser_sel`=1 and `lat_en`=1, word bits 6:0 go to `att_code` and word bit 7 goes to `bad_word`, one clock after sampling.
- R8: While `bad_word`=1, parallel writes are ignored. A serial latch of a word with bit 7 = 0 clears `bad_word` and re-enables parallel writes.
- R9: When a serial clock edge and `lat_en`=1 fall in the same sampled cycle, the latch takes the word as it was before the shift. It takes the shifted word in the following cycle if `lat_en` stays high.
- R10: In serial mode the parallel pins have no effect. In parallel mode `ser_clk` edges leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| ser_sel | input | 1 | Path select: 0 parallel, 1 serial |
| par_data | input | 7 | Parallel attenuation code |
| lat_en | input | 1 | Latch enable, transparent while high |
| ser_din | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| att_code | output | 7 | Attenuation code, 0.25 dB per step |
| bad_word | output | 1 | Last latched serial word had bit 7 set |

## Verification
Two functions can fall in the same cycle: a serial shift and a transparent load from the shift register. The bench provokes this by raising `lat_en` and a `ser_clk` edge on one falling clock edge. It checks that the code first shows the pre-shift word and, one cycle later, the shifted word with its marker bit in `bad_word`. A second collision, a parallel write during a raised invalid flag, is judged by holding the pins active and seeing the code stay put.

// File: rtl/att_ctrl_pkg.sv
package att_ctrl_pkg;

   typedef enum logic {
      PATH_PAR = 1'b0,
      PATH_SER = 1'b1
   } path_e;

   // Number of system clocks in a window given in microseconds
   function automatic int unsigned us_to_cycles(input int unsigned hz,
                                                input int unsigned us);
      return (hz / 1000) * us / 1000;
   endfunction

endpackage

// File: rtl/att_ser_shift.sv
module att_ser_shift #(
   parameter int unsigned WORD_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter bit          RISE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sclk,
   input  logic              sdin,
   output logic [WORD_W-1:0] word
);

   logic sclk_q;
   logic step;

   if (WORD_W < 2) begin : g_bad_w
      $error("att_ser_shift: WORD_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk;
   end

   if (RISE_EDGE) begin : g_rise
      assign step = en & sclk & ~sclk_q;
   end else begin : g_fall
      assign step = en & ~sclk & sclk_q;
   end

   if (LSB_FIRST) begin : g_lsb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    word <= '0;
         else if (step) word <= {sdin, word[WORD_W-1:1]};
      end
   end else begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    word <= '0;
         else if (step) word <= {word[WORD_W-2:0], sdin};
      end
   end

   // R10: no shift when the path is not enabled
   p_idle_keeps_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(word));

endmodule

// File: rtl/att_boot_timer.sv
module att_boot_timer #(
   parameter int unsigned CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   output logic busy
);

   localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

   if (CYCLES == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_cnt
      localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (busy)  cnt <= cnt + 1'b1;
      end

      assign busy = (cnt != LAST);

      // R2: counter never runs past the window length
      p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST);
      // R2: once the window closes it stays closed
      p_window_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |=> !busy);
   end

endmodule

// File: rtl/att_code_reg.sv
module att_code_reg #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_ld,
   input  logic [CODE_W-1:0] par_val,
   input  logic              ser_ld,
   input  logic [CODE_W:0]   ser_word,
   output logic [CODE_W-1:0] code,
   output logic              flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '1;
         flag <= 1'b0;
      end else if (ser_ld) begin
         code <= ser_word[CODE_W-1:0];
         flag <= ser_word[CODE_W];
      end else if (par_ld) begin
         code <= par_val;
      end
   end

   // R8: a parallel load never alters the validity flag
   p_par_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ld && !ser_ld) |=> $stable(flag));

endmodule

// File: rtl/att_ctrl.sv
module att_ctrl #(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned PRESET_US = 400,
   parameter int unsigned CODE_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel,
   input  logic [CODE_W-1:0] par_data,
   input  logic              lat_en,
   input  logic              ser_din,
   input  logic              ser_clk,
   output logic [CODE_W-1:0] att_code,
   output logic              bad_word
);
   import att_ctrl_pkg::*;

   localparam int unsigned WORD_W     = CODE_W + 1;
   localparam int unsigned PRESET_CYC = us_to_cycles(CLK_HZ, PRESET_US);
   localparam logic [CODE_W-1:0] MAX_CODE = '1;

   if (CODE_W < 1 || CODE_W > 15) begin : g_bad_code_w
      $error("att_ctrl: CODE_W out of range");
   end
   if (CLK_HZ < 1000) begin : g_bad_hz
      $error("att_ctrl: CLK_HZ too small for the preset counter");
   end

   path_e             path;
   logic              busy;
   logic              open_gate;
   logic              par_ld;
   logic              ser_ld;
   logic [WORD_W-1:0] sr_word;

   assign path      = ser_sel ? PATH_SER : PATH_PAR;
   assign open_gate = lat_en & ~busy;
   assign ser_ld    = open_gate & (path == PATH_SER);
   assign par_ld    = open_gate & (path == PATH_PAR) & ~bad_word;

   att_ser_shift #(
      .WORD_W    (WORD_W),
      .LSB_FIRST (1'b1),
      .RISE_EDGE (1'b1)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (path == PATH_SER),
      .sclk  (ser_clk),
      .sdin  (ser_din),
      .word  (sr_word)
   );

   att_boot_timer #(
      .CYCLES (PRESET_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (busy)
   );

   att_code_reg #(
      .CODE_W (CODE_W)
   ) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .par_ld   (par_ld),
      .par_val  (par_data),
      .ser_ld   (ser_ld),
      .ser_word (sr_word),
      .code     (att_code),
      .flag     (bad_word)
   );

   // R2: maximum attenuation throughout the preset window
   p_window_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (att_code == MAX_CODE));
   // R4 and R6: enable low freezes the code and the flag
   p_le_low_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_en |=> ($stable(att_code) && $stable(bad_word)));
   // R8: the flag can only be raised by a serial latch
   p_flag_from_serial_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_word) |-> $past(ser_sel));
   // R8: a raised flag blocks parallel writes
   p_flag_blocks_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_word && !ser_sel) |=> $stable(att_code));

endmodule

// File: tb/sim_att_ctrl.sv
`timescale 1ns/1ps
module sim_att_ctrl;

   localparam int unsigned P = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_sel = 1'b0;
   logic [6:0] par_data = '0;
   logic       lat_en = 1'b0;
   logic       ser_din = 1'b0;
   logic       ser_clk = 1'b0;
   logic [6:0] att_code;
   logic       bad_word;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   att_ctrl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_sel  (ser_sel),
      .par_data (par_data),
      .lat_en   (lat_en),
      .ser_din  (ser_din),
      .ser_clk  (ser_clk),
      .att_code (att_code),
      .bad_word (bad_word)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic sel, input logic le, input logic [6:0] pins);
      @(negedge clk);
      rst_n = 1'b0; ser_sel = sel; lat_en = le; par_data = pins;
      ser_clk = 1'b0; ser_din = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 code in reset", {1'b0, att_code}, 8'h7F);
      rst_n = 1'b1;
   endtask

   task automatic send_word(input logic [7:0] w);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); ser_din = w[i]; ser_clk = 1'b1;
         @(negedge clk); ser_clk = 1'b0;
      end
   endtask

   task automatic pulse_le();
      @(negedge clk); lat_en = 1'b1;
      @(negedge clk); lat_en = 1'b0;
   endtask

   task automatic t_powerup_direct();
      do_reset(1'b0, 1'b1, 7'h2A);
      chk("R1 flag after release", {7'b0, bad_word}, 8'h00);
      repeat (P) @(negedge clk);
      chk("R2 max at window end", {1'b0, att_code}, 8'h7F);
      @(negedge clk);
      chk("R3 preset after window", {1'b0, att_code}, 8'h2A);
   endtask

   task automatic t_direct_follow();
      par_data = 7'h05; @(negedge clk);
      chk("R3 direct follow 05", {1'b0, att_code}, 8'h05);
      par_data = 7'h00; @(negedge clk);
      chk("R3 direct follow 00", {1'b0, att_code}, 8'h00);
   endtask

   task automatic t_latched();
      lat_en = 1'b0; par_data = 7'h33;
      repeat (2) @(negedge clk);
      chk("R4 pins ignored with LE low", {1'b0, att_code}, 8'h00);
      pulse_le();
      chk("R4 latched on pulse", {1'b0, att_code}, 8'h33);
      par_data = 7'h11; repeat (3) @(negedge clk);
      chk("R4 hold after pulse", {1'b0, att_code}, 8'h33);
   endtask

   task automatic t_serial();
      ser_sel = 1'b1;
      send_word(8'h5A);
      chk("R6 shift does not move code", {1'b0, att_code}, 8'h33);
      pulse_le();
      chk("R5 R7 serial word latched", {1'b0, att_code}, 8'h5A);
      chk("R7 flag clear", {7'b0, bad_word}, 8'h00);
      par_data = 7'h7F; pulse_le();
      chk("R10 pins ignored in serial", {1'b0, att_code}, 8'h5A);
   endtask

   task automatic t_bad_word();
      send_word(8'h81); pulse_le();
      chk("R7 low bits of marked word", {1'b0, att_code}, 8'h01);
      chk("R8 flag raised", {7'b0, bad_word}, 8'h01);
      ser_sel = 1'b0; par_data = 7'h44; lat_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 parallel blocked", {1'b0, att_code}, 8'h01);
      lat_en = 1'b0; @(negedge clk); ser_sel = 1'b1;
      send_word(8'h12); pulse_le();
      chk("R8 flag cleared", {7'b0, bad_word}, 8'h00);
      chk("R8 clean word code", {1'b0, att_code}, 8'h12);
      ser_sel = 1'b0; lat_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 parallel re-enabled", {1'b0, att_code}, 8'h44);
      lat_en = 1'b0;
   endtask

   task automatic t_par_ignores_sclk();
      send_word(8'h7F);
      ser_sel = 1'b1; @(negedge clk);
      pulse_le();
      chk("R10 no shift in parallel mode", {1'b0, att_code}, 8'h12);
   endtask

   task automatic t_same_cycle();
      @(negedge clk); lat_en = 1'b1; ser_din = 1'b1; ser_clk = 1'b1;
      @(negedge clk);
      chk("R9 pre-shift word latched", {1'b0, att_code}, 8'h12);
      ser_clk = 1'b0;
      @(negedge clk);
      chk("R9 shifted word next cycle", {1'b0, att_code}, 8'h09);
      chk("R9 shifted marker bit", {7'b0, bad_word}, 8'h01);
      lat_en = 1'b0;
   endtask

   task automatic t_powerup_serial();
      do_reset(1'b1, 1'b0, 7'h00);
      repeat (P + 5) @(negedge clk);
      chk("R1 serial powerup stays max", {1'b0, att_code}, 8'h7F);
      chk("R1 serial powerup flag", {7'b0, bad_word}, 8'h00);
      send_word(8'h03); pulse_le();
      chk("R7 first serial word", {1'b0, att_code}, 8'h03);
   endtask

   initial begin
      t_powerup_direct();
      t_direct_follow();
      t_latched();
      t_serial();
      t_bad_word();
      t_par_ignores_sclk();
      t_same_cycle();
      t_powerup_serial();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule